// File: doc/BRIEF.md
# Video and Sliced-Text Output Merger

This block joins two producers onto one output port. One producer is scaled video, the other is sliced text data from the blanking interval. Each producer writes 32-bit words into its own small FIFO. When no packet is on the port, an arbiter chooses a source under a 2-bit policy. A framer then sends that source's packet.

The port is either one byte lane or two byte lanes, chosen by a width bit. Video packets carry a start-of-active-video code, the payload, and an end-of-active-video code, in the four-byte timing-reference style used for component digital video. Text packets are framed one of two ways, chosen by a configuration bit:
- the same timing-reference codes, with the vertical-blanking bit set;
- a five-byte ancillary header, with no trailer.

Each beat is qualified either by a data-valid strobe or by a clock-enable strobe. Every lane reads 00h in any cycle without a beat. A marker output is high for the whole of a text packet. Each FIFO reports empty, full and a threshold-based filled flag.

Top module: `vid_txt_merger`

## Requirements
- R1: Out of reset both FIFOs report empty=1, full=0 and filled=0. Both lanes read 00h, the data-valid strobe is 0 and the text marker is 0.
- R2: A video packet starts only once the video FIFO holds VID_WORDS words. It is the bytes FF,00,00,XY(H=0), then the payload, then FF,00,00,XY(H=1).
  - XY = {1, F, V, H, V^H, F^H, F^V, F^V^H}, with V=0 and F taken from cfg_field.
  - In byte mode each word is sent least significant byte first.
- R3: With cfg_txt_anc=0, a text packet of TXT_WORDS words is framed like video, but with V=1 in both XY codes.
- R4: With cfg_txt_anc=1, a text packet is 00,FF,FF, then cfg_did, then the byte TXT_WORDS, then the payload, with no trailer.
- R5: With cfg_wide=1, each payload word takes two beats: {hi,lo} = bits[15:0], then bits[31:16]. Each framing byte is on the low lane, with 00h on the high lane.
- R6: In every cycle without a qualified beat, out_lo and out_hi are both 00h.
- R7: With cfg_gate=0, beats are marked by out_dv and out_ce is held at 1. With cfg_gate=1, beats are marked by out_ce and out_dv is held at 1.
- R8: Policy cfg_arb=00 gives video priority. When both sources are ready at once, the video packet is sent first, then the text packet.
- R9: Policy cfg_arb=01 gives text priority. When both sources are ready at once, the text packet is sent first.
- R10: Policy 10 never starts a text packet and policy 11 never starts a video packet. The held data stays queued until the policy changes.
- R11: No packet starts before its source holds a whole packet of words. Once started, a packet is sent as one unbroken run of beats, with at least one idle cycle between packets.
- R12: For each FIFO, empty means 0 words, full means DEPTH words, and filled means at least cfg_thr words. A write while full is dropped.
- R13: out_txt is 1 on every beat of a text packet and 0 on every beat of a video packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_arb | input | 2 | Arbitration policy (00 video first, 01 text first, 10 video only, 11 text only) |
| cfg_wide | input | 1 | 1 = two byte lanes, 0 = low lane only |
| cfg_txt_anc | input | 1 | 1 = ancillary header for text, 0 = timing codes |
| cfg_gate | input | 1 | 1 = clock-enable qualifier, 0 = data-valid qualifier |
| cfg_field | input | 1 | Field bit F placed in timing codes |
| cfg_did | input | 8 | Data identifier byte of the ancillary header |
| cfg_thr | input | CW | Fill threshold for the filled flags |
| vid_wr | input | 1 | Video word write strobe |
| vid_wdata | input | 32 | Video word |
| txt_wr | input | 1 | Text word write strobe |
| txt_wdata | input | 32 | Text word |
| vid_empty | output | 1 | Video FIFO empty |
| vid_full | output | 1 | Video FIFO full |
| vid_filled | output | 1 | Video FIFO at or above threshold |
| txt_empty | output | 1 | Text FIFO empty |
| txt_full | output | 1 | Text FIFO full |
| txt_filled | output | 1 | Text FIFO at or above threshold |
| out_lo | output | 8 | Low byte lane |
| out_hi | output | 8 | High byte lane |
| out_dv | output | 1 | Data-valid strobe |
| out_ce | output | 1 | Clock-enable strobe |
| out_txt | output | 1 | Text packet marker |

## Verification
Most wrong internal states show at the port within one packet. A stray beat counter shows up as a shifted or repeated payload byte, or as a missing trailer. A bad arbitration state shows up as the packets arriving in the wrong order, or as a packet sent under an exclusive policy. Both are seen within a few dozen cycles of the FIFOs becoming ready.

A broken occupancy count shows up on the flags as soon as the write that crosses a threshold has been made. It also shows up later, as a drained payload that includes a word written while the FIFO was full. Idle-lane leakage and qualifier mistakes show up in the very cycle they happen.

// File: rtl/vtm_pkg.sv
`timescale 1ns/1ps
package vtm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_PAY  = 2'd2,
      ST_TRL  = 2'd3
   } vtm_state_e;

   localparam logic [1:0] ARB_VID_FIRST = 2'b00;
   localparam logic [1:0] ARB_TXT_FIRST = 2'b01;
   localparam logic [1:0] ARB_VID_ONLY  = 2'b10;
   localparam logic [1:0] ARB_TXT_ONLY  = 2'b11;

   function automatic logic [7:0] timing_xy(input logic f, input logic v, input logic h);
      timing_xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction
endpackage

// File: rtl/vtm_fifo.sv
`timescale 1ns/1ps
module vtm_fifo #(
   parameter int DW    = 32,
   parameter int DEPTH = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [DW-1:0] wdata,
   input  logic          rd,
   input  logic [CW-1:0] thr,
   output logic [DW-1:0] rdata,
   output logic [CW-1:0] cnt,
   output logic          empty,
   output logic          full,
   output logic          filled
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          do_wr, do_rd;

   assign do_wr = wr && !full;
   assign do_rd = rd && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         cnt  <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wdata;
   end

   assign rdata  = mem[rptr];
   assign empty  = (cnt == '0);
   assign full   = (cnt == CW'(DEPTH));
   assign filled = (cnt >= thr);
endmodule

// File: rtl/vtm_arb.sv
`timescale 1ns/1ps
module vtm_arb
   import vtm_pkg::*;
(
   input  logic [1:0] mode,
   input  logic       vid_rdy,
   input  logic       txt_rdy,
   input  logic       busy,
   output logic       gnt_v,
   output logic       gnt_t
);
   always_comb begin
      gnt_v = 1'b0;
      gnt_t = 1'b0;
      if (!busy) begin
         case (mode)
            ARB_VID_FIRST: begin
               gnt_v = vid_rdy;
               gnt_t = txt_rdy && !vid_rdy;
            end
            ARB_TXT_FIRST: begin
               gnt_t = txt_rdy;
               gnt_v = vid_rdy && !txt_rdy;
            end
            ARB_VID_ONLY: gnt_v = vid_rdy;
            default:      gnt_t = txt_rdy;
         endcase
      end
   end
endmodule

// File: rtl/vtm_framer.sv
`timescale 1ns/1ps
module vtm_framer
   import vtm_pkg::*;
#(
   parameter int VID_WORDS = 4,
   parameter int TXT_WORDS = 2,
   localparam int MAXW     = (VID_WORDS > TXT_WORDS) ? VID_WORDS : TXT_WORDS,
   localparam int WIW      = $clog2(MAXW + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        gnt_v,
   input  logic        gnt_t,
   input  logic        cfg_wide,
   input  logic        cfg_anc,
   input  logic        cfg_field,
   input  logic [7:0]  cfg_did,
   input  logic [31:0] vid_d,
   input  logic [31:0] txt_d,
   output logic        pop_v,
   output logic        pop_t,
   output logic        busy,
   output logic        beat_v,
   output logic [7:0]  lo,
   output logic [7:0]  hi,
   output logic        is_txt
);
   vtm_state_e     st;
   logic           src_txt, wide_l, anc_l, field_l;
   logic [7:0]     did_l;
   logic [2:0]     idx;
   logic [1:0]     bi;
   logic [WIW-1:0] wi;
   logic [31:0]    word;
   logic [7:0]     code;
   logic           anc_pkt, last_beat, last_word, last_hdr;
   logic [WIW-1:0] wi_last;

   assign anc_pkt   = src_txt && anc_l;
   assign word      = src_txt ? txt_d : vid_d;
   assign last_beat = wide_l ? (bi == 2'd1) : (bi == 2'd3);
   assign wi_last   = src_txt ? WIW'(TXT_WORDS - 1) : WIW'(VID_WORDS - 1);
   assign last_word = (wi == wi_last);
   assign last_hdr  = anc_pkt ? (idx == 3'd4) : (idx == 3'd3);
   assign busy      = (st != ST_IDLE);
   assign is_txt    = busy && src_txt;

   always_comb begin
      code = 8'h00;
      if (anc_pkt && st == ST_HDR) begin
         case (idx)
            3'd0:    code = 8'h00;
            3'd1:    code = 8'hFF;
            3'd2:    code = 8'hFF;
            3'd3:    code = did_l;
            default: code = 8'(TXT_WORDS);
         endcase
      end else begin
         case (idx)
            3'd0:    code = 8'hFF;
            3'd1:    code = 8'h00;
            3'd2:    code = 8'h00;
            default: code = timing_xy(field_l, src_txt, st == ST_TRL);
         endcase
      end
   end

   always_comb begin
      beat_v = 1'b0;
      lo     = 8'h00;
      hi     = 8'h00;
      pop_v  = 1'b0;
      pop_t  = 1'b0;
      case (st)
         ST_HDR, ST_TRL: begin
            beat_v = 1'b1;
            lo     = code;
         end
         ST_PAY: begin
            beat_v = 1'b1;
            if (wide_l) begin
               if (bi == 2'd0) {hi, lo} = word[15:0];
               else            {hi, lo} = word[31:16];
            end else begin
               case (bi)
                  2'd0:    lo = word[7:0];
                  2'd1:    lo = word[15:8];
                  2'd2:    lo = word[23:16];
                  default: lo = word[31:24];
               endcase
            end
            pop_v = last_beat && !src_txt;
            pop_t = last_beat && src_txt;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         src_txt <= 1'b0;
         wide_l  <= 1'b0;
         anc_l   <= 1'b0;
         field_l <= 1'b0;
         did_l   <= 8'h00;
         idx     <= '0;
         bi      <= '0;
         wi      <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (gnt_v || gnt_t) begin
                  st      <= ST_HDR;
                  src_txt <= gnt_t;
                  wide_l  <= cfg_wide;
                  anc_l   <= cfg_anc;
                  field_l <= cfg_field;
                  did_l   <= cfg_did;
                  idx     <= '0;
               end
            end
            ST_HDR: begin
               idx <= idx + 3'd1;
               if (last_hdr) begin
                  st <= ST_PAY;
                  bi <= '0;
                  wi <= '0;
               end
            end
            ST_PAY: begin
               bi <= bi + 2'd1;
               if (last_beat) begin
                  bi <= '0;
                  wi <= wi + 1'b1;
                  if (last_word) begin
                     st  <= anc_pkt ? ST_IDLE : ST_TRL;
                     idx <= '0;
                  end
               end
            end
            default: begin
               idx <= idx + 3'd1;
               if (idx == 3'd3) st <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/vid_txt_merger.sv
`timescale 1ns/1ps
module vid_txt_merger #(
   parameter int DEPTH     = 8,
   parameter int VID_WORDS = 4,
   parameter int TXT_WORDS = 2,
   localparam int CW       = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [1:0]    cfg_arb,
   input  logic          cfg_wide,
   input  logic          cfg_txt_anc,
   input  logic          cfg_gate,
   input  logic          cfg_field,
   input  logic [7:0]    cfg_did,
   input  logic [CW-1:0] cfg_thr,
   input  logic          vid_wr,
   input  logic [31:0]   vid_wdata,
   input  logic          txt_wr,
   input  logic [31:0]   txt_wdata,
   output logic          vid_empty,
   output logic          vid_full,
   output logic          vid_filled,
   output logic          txt_empty,
   output logic          txt_full,
   output logic          txt_filled,
   output logic [7:0]    out_lo,
   output logic [7:0]    out_hi,
   output logic          out_dv,
   output logic          out_ce,
   output logic          out_txt
);
   localparam int NSRC = 2;
   localparam int NEED_V = VID_WORDS;
   localparam int NEED_T = TXT_WORDS;

   if ((DEPTH & (DEPTH - 1)) != 0 || DEPTH < 2) begin : g_bad_depth
      initial $fatal(1, "DEPTH must be a power of two of at least 2");
   end
   if (VID_WORDS < 1 || VID_WORDS > DEPTH || TXT_WORDS < 1 || TXT_WORDS > DEPTH) begin : g_bad_words
      initial $fatal(1, "packet word counts must lie within 1..DEPTH");
   end
   if (TXT_WORDS > 255) begin : g_bad_wc
      initial $fatal(1, "TXT_WORDS must fit the count byte");
   end

   logic          wr_s    [NSRC];
   logic [31:0]   wd_s    [NSRC];
   logic          rd_s    [NSRC];
   logic [31:0]   rdat_s  [NSRC];
   logic [CW-1:0] cnt_s   [NSRC];
   logic          emp_s   [NSRC];
   logic          ful_s   [NSRC];
   logic          fil_s   [NSRC];

   logic gnt_v, gnt_t, pop_v, pop_t, busy, beat_v;
   logic vid_rdy, txt_rdy;

   assign wr_s[0] = vid_wr;
   assign wd_s[0] = vid_wdata;
   assign wr_s[1] = txt_wr;
   assign wd_s[1] = txt_wdata;
   assign rd_s[0] = pop_v;
   assign rd_s[1] = pop_t;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      vtm_fifo #(.DW(32), .DEPTH(DEPTH)) u_fifo (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr     (wr_s[s]),
         .wdata  (wd_s[s]),
         .rd     (rd_s[s]),
         .thr    (cfg_thr),
         .rdata  (rdat_s[s]),
         .cnt    (cnt_s[s]),
         .empty  (emp_s[s]),
         .full   (ful_s[s]),
         .filled (fil_s[s])
      );
   end

   assign vid_rdy = (cnt_s[0] >= CW'(NEED_V));
   assign txt_rdy = (cnt_s[1] >= CW'(NEED_T));

   vtm_arb u_arb (
      .mode    (cfg_arb),
      .vid_rdy (vid_rdy),
      .txt_rdy (txt_rdy),
      .busy    (busy),
      .gnt_v   (gnt_v),
      .gnt_t   (gnt_t)
   );

   vtm_framer #(.VID_WORDS(VID_WORDS), .TXT_WORDS(TXT_WORDS)) u_framer (
      .clk       (clk),
      .rst_n     (rst_n),
      .gnt_v     (gnt_v),
      .gnt_t     (gnt_t),
      .cfg_wide  (cfg_wide),
      .cfg_anc   (cfg_txt_anc),
      .cfg_field (cfg_field),
      .cfg_did   (cfg_did),
      .vid_d     (rdat_s[0]),
      .txt_d     (rdat_s[1]),
      .pop_v     (pop_v),
      .pop_t     (pop_t),
      .busy      (busy),
      .beat_v    (beat_v),
      .lo        (out_lo),
      .hi        (out_hi),
      .is_txt    (out_txt)
   );

   assign out_dv = cfg_gate ? 1'b1 : beat_v;
   assign out_ce = cfg_gate ? beat_v : 1'b1;

   assign vid_empty  = emp_s[0];
   assign vid_full   = ful_s[0];
   assign vid_filled = fil_s[0];
   assign txt_empty  = emp_s[1];
   assign txt_full   = ful_s[1];
   assign txt_filled = fil_s[1];
endmodule

// File: rtl/vtm_checker.sv
`timescale 1ns/1ps
module vtm_checker (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] cfg_arb,
   input logic       cfg_gate,
   input logic       vid_empty,
   input logic       vid_full,
   input logic       txt_empty,
   input logic       txt_full,
   input logic [7:0] out_lo,
   input logic [7:0] out_hi,
   input logic       out_dv,
   input logic       out_ce,
   input logic       out_txt
);
   logic qual;
   assign qual = cfg_gate ? out_ce : out_dv;

   // R6
   idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !qual |-> (out_lo == 8'h00 && out_hi == 8'h00));

   // R7
   qual_tie_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_gate ? out_dv : out_ce);

   // R11
   marker_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_txt) |-> !qual);

   // R10
   vonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_txt) |-> $past(cfg_arb) != 2'b10);

   // R10
   tonly_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(qual) && !out_txt) |-> $past(cfg_arb) != 2'b11);

   // R12
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(vid_full && vid_empty) && !(txt_full && txt_empty));
endmodule

bind vid_txt_merger vtm_checker u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_arb   (cfg_arb),
   .cfg_gate  (cfg_gate),
   .vid_empty (vid_empty),
   .vid_full  (vid_full),
   .txt_empty (txt_empty),
   .txt_full  (txt_full),
   .out_lo    (out_lo),
   .out_hi    (out_hi),
   .out_dv    (out_dv),
   .out_ce    (out_ce),
   .out_txt   (out_txt)
);

// File: tb/vid_txt_merger_bench.sv
`timescale 1ns/1ps
module vid_txt_merger_bench;
   localparam int DEPTH = 8;
   localparam int VW    = 4;
   localparam int TW    = 2;
   localparam int CW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    cfg_arb = 2'b00;
   logic          cfg_wide = 1'b0, cfg_txt_anc = 1'b0, cfg_gate = 1'b0, cfg_field = 1'b0;
   logic [7:0]    cfg_did = 8'h00;
   logic [CW-1:0] cfg_thr = CW'(3);
   logic          vid_wr = 1'b0, txt_wr = 1'b0;
   logic [31:0]   vid_wdata = '0, txt_wdata = '0;
   logic          vid_empty, vid_full, vid_filled, txt_empty, txt_full, txt_filled;
   logic [7:0]    out_lo, out_hi;
   logic          out_dv, out_ce, out_txt;

   always #2 clk = ~clk;

   vid_txt_merger #(.DEPTH(DEPTH), .VID_WORDS(VW), .TXT_WORDS(TW)) u_vid_txt_merger (
      .clk(clk), .rst_n(rst_n), .cfg_arb(cfg_arb), .cfg_wide(cfg_wide),
      .cfg_txt_anc(cfg_txt_anc), .cfg_gate(cfg_gate), .cfg_field(cfg_field),
      .cfg_did(cfg_did), .cfg_thr(cfg_thr), .vid_wr(vid_wr), .vid_wdata(vid_wdata),
      .txt_wr(txt_wr), .txt_wdata(txt_wdata), .vid_empty(vid_empty), .vid_full(vid_full),
      .vid_filled(vid_filled), .txt_empty(txt_empty), .txt_full(txt_full),
      .txt_filled(txt_filled), .out_lo(out_lo), .out_hi(out_hi), .out_dv(out_dv),
      .out_ce(out_ce), .out_txt(out_txt)
   );

   int n_chk = 0, n_fail = 0;
   int idle_bad = 0, tie_bad = 0, runs = 0;
   bit prev_v = 1'b0;
   bit finished = 1'b0;
   logic [16:0] got_q [$];
   logic [16:0] exp_q [$];
   logic [31:0] pw [16];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         bit v, tie;
         v   = cfg_gate ? out_ce : out_dv;
         tie = cfg_gate ? out_dv : out_ce;
         if (!tie) tie_bad++;
         if (v) begin
            got_q.push_back({out_txt, out_hi, out_lo});
            if (!prev_v) runs++;
         end else if (out_lo != 8'h00 || out_hi != 8'h00) begin
            idle_bad++;
         end
         prev_v = v;
      end
   end

   function automatic logic [7:0] xy(input bit f, input bit v, input bit h);
      return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
   endfunction

   task automatic exp_byte(input bit t, input logic [7:0] b);
      exp_q.push_back({t, 8'h00, b});
   endtask

   task automatic exp_pkt(input bit t, input bit anc, input bit wide, input bit f,
                          input logic [7:0] did, input int first, input int n);
      if (t && anc) begin
         exp_byte(t, 8'h00); exp_byte(t, 8'hFF); exp_byte(t, 8'hFF);
         exp_byte(t, did);   exp_byte(t, 8'(n));
      end else begin
         exp_byte(t, 8'hFF); exp_byte(t, 8'h00); exp_byte(t, 8'h00);
         exp_byte(t, xy(f, t, 1'b0));
      end
      for (int k = 0; k < n; k++) begin
         logic [31:0] w;
         w = pw[first + k];
         if (wide) begin
            exp_q.push_back({t, w[15:8], w[7:0]});
            exp_q.push_back({t, w[31:24], w[23:16]});
         end else begin
            for (int b = 0; b < 4; b++) exp_byte(t, w[8*b +: 8]);
         end
      end
      if (!(t && anc)) begin
         exp_byte(t, 8'hFF); exp_byte(t, 8'h00); exp_byte(t, 8'h00);
         exp_byte(t, xy(f, t, 1'b1));
      end
   endtask

   task automatic check_stream(input string req);
      bit ok;
      int bad;
      ok  = (got_q.size() == exp_q.size());
      bad = -1;
      if (ok) begin
         foreach (exp_q[i]) begin
            if (got_q[i] !== exp_q[i] && bad < 0) bad = i;
         end
      end
      if (!ok) chk(1'b0, req, "beat count", got_q.size(), exp_q.size());
      else if (bad >= 0) chk(1'b0, req, $sformatf("beat %0d", bad), got_q[bad], exp_q[bad]);
      else chk(1'b1, req, "stream", 0, 0);
      got_q.delete();
      exp_q.delete();
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr_vid(input logic [31:0] d);
      vid_wr = 1'b1; vid_wdata = d;
      @(posedge clk); #1;
      vid_wr = 1'b0;
   endtask

   task automatic wr_txt(input logic [31:0] d);
      txt_wr = 1'b1; txt_wdata = d;
      @(posedge clk); #1;
      txt_wr = 1'b0;
   endtask

   task automatic wr_both(input logic [31:0] dv, input logic [31:0] dt);
      vid_wr = 1'b1; vid_wdata = dv; txt_wr = 1'b1; txt_wdata = dt;
      @(posedge clk); #1;
      vid_wr = 1'b0; txt_wr = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(vid_empty == 1'b1 && txt_empty == 1'b1, "R1", "empty flags", {vid_empty, txt_empty}, 2'b11);
      chk(!vid_full && !txt_full && !vid_filled && !txt_filled, "R1", "full/filled",
          {vid_full, txt_full, vid_filled, txt_filled}, 0);
      chk(out_lo == 8'h00 && out_hi == 8'h00, "R1", "lanes", {out_hi, out_lo}, 0);
      chk(!out_dv && !out_txt, "R1", "dv/marker", {out_dv, out_txt}, 0);
      @(posedge clk); #1;
   endtask

   task automatic t_video_byte();
      cfg_arb = 2'b00; cfg_wide = 1'b0; cfg_field = 1'b1;
      for (int i = 0; i < 3; i++) wr_vid(pw[i]);
      tick(10);
      chk(got_q.size() == 0, "R11", "early start", got_q.size(), 0);
      wr_vid(pw[3]);
      runs = 0;
      tick(40);
      chk(runs == 1, "R11", "contiguous runs", runs, 1);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 0, VW);
      check_stream("R2");
   endtask

   task automatic t_video_wide();
      cfg_wide = 1'b1; cfg_field = 1'b0;
      for (int i = 0; i < 4; i++) wr_vid(pw[4 + i]);
      tick(30);
      exp_pkt(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4, VW);
      check_stream("R5");
      cfg_wide = 1'b0;
   endtask

   task automatic t_text_codes();
      cfg_txt_anc = 1'b0; cfg_field = 1'b1;
      wr_txt(pw[8]); wr_txt(pw[9]);
      tick(30);
      exp_pkt(1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8, TW);
      check_stream("R3 R13");
   endtask

   task automatic t_text_anc();
      cfg_txt_anc = 1'b1; cfg_did = 8'h5A;
      wr_txt(pw[10]); wr_txt(pw[11]);
      tick(30);
      exp_pkt(1'b1, 1'b1, 1'b0, 1'b0, 8'h5A, 10, TW);
      check_stream("R4");
      cfg_wide = 1'b1; cfg_did = 8'hC3;
      wr_txt(pw[12]); wr_txt(pw[13]);
      tick(30);
      exp_pkt(1'b1, 1'b1, 1'b1, 1'b0, 8'hC3, 12, TW);
      check_stream("R4 R5");
      cfg_wide = 1'b0; cfg_txt_anc = 1'b0;
   endtask

   task automatic t_gated();
      cfg_gate = 1'b1; cfg_field = 1'b0;
      tick(1);
      for (int i = 0; i < 4; i++) wr_vid(pw[i]);
      tick(40);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, VW);
      check_stream("R7");
      cfg_gate = 1'b0;
      tick(1);
      chk(tie_bad == 0, "R7", "unused strobe held high", tie_bad, 0);
   endtask

   task automatic load_pair();
      wr_vid(pw[0]); wr_vid(pw[1]);
      wr_both(pw[2], pw[8]);
      wr_both(pw[3], pw[9]);
   endtask

   task automatic t_priority();
      cfg_arb = 2'b00; cfg_field = 1'b0;
      load_pair();
      tick(70);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, VW);
      exp_pkt(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8, TW);
      check_stream("R8");
      cfg_arb = 2'b01;
      load_pair();
      tick(70);
      exp_pkt(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8, TW);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, VW);
      check_stream("R9");
   endtask

   task automatic t_exclusive();
      cfg_arb = 2'b10;
      wr_txt(pw[14]); wr_txt(pw[15]);
      tick(30);
      chk(got_q.size() == 0, "R10", "text under video-only", got_q.size(), 0);
      chk(txt_empty == 1'b0, "R10", "text held", txt_empty, 0);
      cfg_arb = 2'b11;
      tick(30);
      exp_pkt(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 14, TW);
      check_stream("R10");
      for (int i = 0; i < 4; i++) wr_vid(pw[4 + i]);
      tick(30);
      chk(got_q.size() == 0, "R10", "video under text-only", got_q.size(), 0);
      chk(vid_empty == 1'b0, "R10", "video held", vid_empty, 0);
      cfg_arb = 2'b10;
      tick(40);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4, VW);
      check_stream("R10");
   endtask

   task automatic t_flags();
      cfg_arb = 2'b11; cfg_thr = CW'(3);
      wr_vid(pw[0]); wr_vid(pw[1]);
      chk(!vid_empty && !vid_filled && !vid_full, "R12", "two words",
          {vid_empty, vid_filled, vid_full}, 0);
      wr_vid(pw[2]);
      chk(vid_filled && !vid_full, "R12", "at threshold", {vid_filled, vid_full}, 2'b10);
      for (int i = 3; i < 8; i++) wr_vid(pw[i]);
      chk(vid_full == 1'b1, "R12", "full", vid_full, 1);
      wr_vid(32'hDEADBEEF);
      chk(vid_full == 1'b1, "R12", "full after extra write", vid_full, 1);
      cfg_arb = 2'b10;
      tick(80);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 0, VW);
      exp_pkt(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 4, VW);
      check_stream("R12");
      chk(vid_empty == 1'b1, "R12", "drained", vid_empty, 1);
   endtask

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected done");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 16; i++) pw[i] = 32'h1A2B3C4D ^ (i * 32'h01030507) ^ (i << 28);
      tick(4);
      rst_n = 1'b1;
      t_reset();
      t_video_byte();
      t_video_wide();
      t_text_codes();
      t_text_anc();
      t_gated();
      t_priority();
      t_exclusive();
      t_flags();
      chk(idle_bad == 0, "R6", "idle lanes nonzero", idle_bad, 0);
      finished = 1'b1;
      summary();
      $finish;
   end
endmodule